// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Error Detection

This block turns an asynchronous serial line into parallel characters. A x16 sampling tick comes from an external baud-rate timer. The input passes through a synchronizer first. A low level seen on a tick while the receiver is hunting starts a candidate character. The start bit is checked again at its middle, and a line that has already gone high there is treated as noise. The receiver then goes back to hunting.

A valid start bit is followed by 5 to 8 data bits, an optional parity bit and one stop bit, each sampled once at its centre. The completed character goes into a single holding register together with its status flags: parity error, framing error, break and overrun. It stays there until the host acknowledges it. A line held low for a whole frame is reported as a break, with a one-cycle pulse when the break begins and another when the line first returns high. A break that starts partway through a character is also caught. That character is delivered with a framing error, and the following all-zero frame is reported as the break.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, rdValid, breakStart and breakEnd are low and the receiver is hunting for a start bit.
- R2: If the line is high again 8 ticks after the tick that saw it low, the start is discarded: no character is delivered and hunting resumes.
- R3: Data bits arrive least significant first. cfgLen selects the length as cfgLen+5 bits (0=5, 3=8). rxData holds the bits right-justified, with the unused upper bits zero.
- R4: With cfgParEn high, a parity bit follows the data. cfgParMode selects the check: 0 means even (data plus parity hold an even count of ones), 1 means odd, 2 means the bit must be 0, and 3 means the bit must be 1. A mismatch sets statParity. With cfgParEn low, statParity is 0.
- R5: A stop bit sampled as 0 sets statFraming for that character.
- R6: When every data bit, the parity bit (if enabled) and the stop bit sample 0, the character is delivered as zero with statBreak and statFraming set, and breakStart pulses for one cycle.
- R7: After a break, no character is delivered until the line returns high. breakEnd then pulses once, and never without a preceding breakStart.
- R8: A break that begins in the middle of a character produces that character with statFraming set, followed by a break character and a breakStart pulse.
- R9: rdValid stays high and rxData and its flags stay unchanged until rdAck is high in a cycle where rdValid is high. After that cycle rdValid is low, unless a new character completes in that same cycle.
- R10: A character that completes while rdValid is high and rdAck is low is discarded, and statOverrun is set. statOverrun stays set alongside the held character until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| cfgLen | input | 2 | Data length code, bits = cfgLen + 5 |
| cfgParEn | input | 1 | A parity bit follows the data |
| cfgParMode | input | 2 | Parity check: 0 even, 1 odd, 2 forced 0, 3 forced 1 |
| rdAck | input | 1 | Host consumes the held character |
| rdValid | output | 1 | A character is held for the host |
| rxData | output | 8 | Held character, right-justified |
| statParity | output | 1 | Parity error for the held character |
| statFraming | output | 1 | Framing error for the held character |
| statBreak | output | 1 | Held character is a break |
| statOverrun | output | 1 | A later character was lost while this one waited |
| breakStart | output | 1 | One-cycle pulse when a break is detected |
| breakEnd | output | 1 | One-cycle pulse when the line leaves a break |

## Verification
The assertions assume that rdAck is asserted only as a single-cycle acknowledgement of a held character. They also assume that the configuration inputs change only while the line is idle. The stimulus respects both. Acknowledgements come from a monitor that pulses rdAck for exactly one cycle after comparing a character, and the configuration is changed only between frames, after a high gap. Bit times on the line are whole multiples of 16 ticks, so every centre sample falls well inside its bit. The deliberate violations are a short low glitch and a line held low across frame boundaries; neither breaks the acknowledgement or configuration assumptions.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BREAK
  } rxState_t;

  // Strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic clearFrame;  // new start bit seen: clear assembly state
    logic shiftData;   // sample a data bit
    logic capParity;   // sample the parity bit
    logic finish;      // sample the stop bit and deliver
    logic brkStart;    // delivered character is a break
    logic brkEnd;      // line returned high after a break
  } rxStrobe_t;

  localparam logic [1:0] PAR_EVEN = 2'd0;
  localparam logic [1:0] PAR_ODD  = 2'd1;
  localparam logic [1:0] PAR_ZERO = 2'd2;
  localparam logic [1:0] PAR_ONE  = 2'd3;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MAXBITS    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxS,
  input  logic       sawOne,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  output rxStrobe_t  strobe
);

  localparam int CNTW = $clog2(OVERSAMPLE);
  localparam int BITW = $clog2(MAXBITS);
  localparam logic [CNTW-1:0] HALF_LAST = CNTW'(OVERSAMPLE / 2 - 1);
  localparam logic [CNTW-1:0] FULL_LAST = CNTW'(OVERSAMPLE - 1);
  localparam logic [BITW-1:0] LEN_BASE  = BITW'(MAXBITS - 4);

  rxState_t        state, nextState;
  logic [CNTW-1:0] cnt, nextCnt;
  logic [BITW-1:0] bitIdx, nextBit;
  logic [BITW-1:0] lastBit;

  assign lastBit = BITW'(cfgLen) + LEN_BASE;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = cnt;
    nextBit   = bitIdx;
    if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!rxS) begin
            nextState         = ST_START;
            nextCnt           = '0;
            strobe.clearFrame = 1'b1;
          end
        end
        ST_START: begin
          if (cnt == HALF_LAST) begin
            nextCnt = '0;
            nextBit = '0;
            if (rxS) nextState = ST_IDLE;
            else     nextState = ST_DATA;
          end else begin
            nextCnt = cnt + CNTW'(1);
          end
        end
        ST_DATA: begin
          if (cnt == FULL_LAST) begin
            strobe.shiftData = 1'b1;
            nextCnt          = '0;
            if (bitIdx == lastBit) nextState = cfgParEn ? ST_PARITY : ST_STOP;
            else                   nextBit   = bitIdx + BITW'(1);
          end else begin
            nextCnt = cnt + CNTW'(1);
          end
        end
        ST_PARITY: begin
          if (cnt == FULL_LAST) begin
            strobe.capParity = 1'b1;
            nextCnt          = '0;
            nextState        = ST_STOP;
          end else begin
            nextCnt = cnt + CNTW'(1);
          end
        end
        ST_STOP: begin
          if (cnt == FULL_LAST) begin
            strobe.finish = 1'b1;
            nextCnt       = '0;
            if (!rxS && !sawOne) begin
              strobe.brkStart = 1'b1;
              nextState       = ST_BREAK;
            end else begin
              nextState = ST_IDLE;
            end
          end else begin
            nextCnt = cnt + CNTW'(1);
          end
        end
        ST_BREAK: begin
          if (rxS) begin
            strobe.brkEnd = 1'b1;
            nextState     = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      bitIdx <= nextBit;
    end
  end

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAXBITS     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serialIn,
  input  rxStrobe_t          strobe,
  input  logic [1:0]         cfgLen,
  input  logic               cfgParEn,
  input  logic [1:0]         cfgParMode,
  input  logic               rdAck,
  output logic               rxS,
  output logic               sawOne,
  output logic               rdValid,
  output logic [MAXBITS-1:0] rxData,
  output logic               statParity,
  output logic               statFraming,
  output logic               statBreak,
  output logic               statOverrun,
  output logic               breakStart,
  output logic               breakEnd
);

  localparam logic [1:0] SPAN = 2'd3;  // MAXBITS minus shortest length

  logic [SYNC_STAGES-1:0] syncQ;
  logic [MAXBITS-1:0]     shiftReg;
  logic [MAXBITS-1:0]     alignedData;
  logic [1:0]             shiftAmt;
  logic                   parBit;
  logic                   dataOnes;
  logic                   parErr;
  logic                   loadChar;

  // Input synchronizer, resets to the idle level
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], serialIn};
  end
  assign rxS = syncQ[SYNC_STAGES-1];

  // Assembly: bits enter at the top and move down, LSB first on the line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      sawOne   <= 1'b0;
    end else if (strobe.clearFrame) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      sawOne   <= 1'b0;
    end else begin
      if (strobe.shiftData) shiftReg <= {rxS, shiftReg[MAXBITS-1:1]};
      if (strobe.capParity) parBit   <= rxS;
      if ((strobe.shiftData || strobe.capParity) && rxS) sawOne <= 1'b1;
    end
  end

  assign shiftAmt    = SPAN - cfgLen;
  assign alignedData = shiftReg >> shiftAmt;
  assign dataOnes    = ^alignedData;

  always_comb begin
    parErr = 1'b0;
    if (cfgParEn) begin
      case (cfgParMode)
        PAR_EVEN: parErr = dataOnes ^ parBit;
        PAR_ODD:  parErr = ~(dataOnes ^ parBit);
        PAR_ZERO: parErr = parBit;
        default:  parErr = ~parBit;
      endcase
    end
  end

  assign loadChar = strobe.finish && (!rdValid || rdAck);

  // Holding register and per-character status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid     <= 1'b0;
      rxData      <= '0;
      statParity  <= 1'b0;
      statFraming <= 1'b0;
      statBreak   <= 1'b0;
      statOverrun <= 1'b0;
    end else if (loadChar) begin
      rdValid     <= 1'b1;
      rxData      <= alignedData;
      statParity  <= parErr;
      statFraming <= ~rxS;
      statBreak   <= strobe.brkStart;
      statOverrun <= 1'b0;
    end else if (strobe.finish) begin
      statOverrun <= 1'b1;
    end else if (rdAck && rdValid) begin
      rdValid     <= 1'b0;
      statOverrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      breakStart <= 1'b0;
      breakEnd   <= 1'b0;
    end else begin
      breakStart <= strobe.brkStart;
      breakEnd   <= strobe.brkEnd;
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MAXBITS     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               serialIn,
  input  logic [1:0]         cfgLen,
  input  logic               cfgParEn,
  input  logic [1:0]         cfgParMode,
  input  logic               rdAck,
  output logic               rdValid,
  output logic [MAXBITS-1:0] rxData,
  output logic               statParity,
  output logic               statFraming,
  output logic               statBreak,
  output logic               statOverrun,
  output logic               breakStart,
  output logic               breakEnd
);

  rxStrobe_t strobe;
  logic      rxS;
  logic      sawOne;

  rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .MAXBITS   (MAXBITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .rxS     (rxS),
    .sawOne  (sawOne),
    .cfgLen  (cfgLen),
    .cfgParEn(cfgParEn),
    .strobe  (strobe)
  );

  rx_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MAXBITS    (MAXBITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .strobe     (strobe),
    .cfgLen     (cfgLen),
    .cfgParEn   (cfgParEn),
    .cfgParMode (cfgParMode),
    .rdAck      (rdAck),
    .rxS        (rxS),
    .sawOne     (sawOne),
    .rdValid    (rdValid),
    .rxData     (rxData),
    .statParity (statParity),
    .statFraming(statFraming),
    .statBreak  (statBreak),
    .statOverrun(statOverrun),
    .breakStart (breakStart),
    .breakEnd   (breakEnd)
  );

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int MAXBITS = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               rdAck,
  input logic               rdValid,
  input logic [MAXBITS-1:0] rxData,
  input logic               statFraming,
  input logic               statBreak,
  input logic               statOverrun,
  input logic               breakStart,
  input logic               breakEnd
);

  logic inBreak;

  always_ff @(posedge clk) begin
    if (!rstN)           inBreak <= 1'b0;
    else if (breakStart) inBreak <= 1'b1;
    else if (breakEnd)   inBreak <= 1'b0;
  end

  AST_BRK_IS_ZERO_FRAMED: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && statBreak) |-> (statFraming && (rxData == '0))); // R6

  AST_BRK_NOT_NESTED: assert property (@(posedge clk) disable iff (!rstN)
    breakStart |-> !inBreak); // R6

  AST_BRK_END_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    breakEnd |-> inBreak); // R7

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdAck) |=> (rdValid && $stable(rxData) && $stable(statBreak))); // R9

  AST_DROP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdValid) |-> $past(rdAck)); // R9

  AST_OVERRUN_WITH_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    statOverrun |-> rdValid); // R10

  AST_READ_CLEARS_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdAck) |=> !statOverrun); // R10

endmodule

bind uart_rx_core uart_rx_core_chk #(.MAXBITS(MAXBITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdAck      (rdAck),
  .rdValid    (rdValid),
  .rxData     (rxData),
  .statFraming(statFraming),
  .statBreak  (statBreak),
  .statOverrun(statOverrun),
  .breakStart (breakStart),
  .breakEnd   (breakEnd)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_TICKS  = 16;

  typedef struct packed {
    logic [7:0] d;
    logic       p;
    logic       f;
    logic       b;
    logic       o;
  } exp_t;

  logic       clk;
  logic       rstN;
  logic       tick;
  logic       serialIn;
  logic [1:0] cfgLen;
  logic       cfgParEn;
  logic [1:0] cfgParMode;
  logic       rdAck;
  logic       rdValid;
  logic [7:0] rxData;
  logic       statParity;
  logic       statFraming;
  logic       statBreak;
  logic       statOverrun;
  logic       breakStart;
  logic       breakEnd;

  exp_t  expQ[$];
  string tagQ[$];
  exp_t  eCur;
  string tCur;
  int    checks;
  int    bad;
  int    rxCount;
  int    brkStartCnt;
  int    brkEndCnt;
  int    tickPhase;
  logic  holdReads;
  int    snapCount;
  int    snapStart;

  uart_rx_core dut (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .serialIn   (serialIn),
    .cfgLen     (cfgLen),
    .cfgParEn   (cfgParEn),
    .cfgParMode (cfgParMode),
    .rdAck      (rdAck),
    .rdValid    (rdValid),
    .rxData     (rxData),
    .statParity (statParity),
    .statFraming(statFraming),
    .statBreak  (statBreak),
    .statOverrun(statOverrun),
    .breakStart (breakStart),
    .breakEnd   (breakEnd)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // x16 tick: one cycle in three
  initial begin
    tick      = 1'b0;
    tickPhase = 0;
    forever begin
      @(negedge clk);
      tickPhase = (tickPhase + 1) % 3;
      tick      = (tickPhase == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic calcPar(input logic [7:0] d, input int n, input logic [1:0] mode);
    logic ones;
    ones = 1'b0;
    for (int i = 0; i < n; i++) ones ^= d[i];
    case (mode)
      2'd0:    return ones;
      2'd1:    return ~ones;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic setLine(input logic v, input int nTicks);
    #1 serialIn = v;
    waitTicks(nTicks);
  endtask

  task automatic sendChar(input logic [7:0] d, input int n, input logic usePar,
                          input logic parBit, input logic stopBit);
    setLine(1'b0, BIT_TICKS);
    for (int i = 0; i < n; i++) setLine(d[i], BIT_TICKS);
    if (usePar) setLine(parBit, BIT_TICKS);
    setLine(stopBit, BIT_TICKS);
    setLine(1'b1, 2 * BIT_TICKS);
  endtask

  task automatic pushExp(input logic [7:0] d, input logic p, input logic f,
                         input logic b, input logic o, input string tag);
    exp_t e;
    e.d = d; e.p = p; e.f = f; e.b = b; e.o = o;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Scoreboard driver: expected item from the requirements, then the frame
  task automatic xmit(input logic [7:0] d, input int n, input logic parBit,
                      input logic stopBit, input string tag);
    logic [7:0] mask;
    logic       pe;
    mask = 8'((9'd1 << n) - 9'd1);
    pe   = cfgParEn && (parBit != calcPar(d, n, cfgParMode));
    pushExp(d & mask, pe, ~stopBit, 1'b0, 1'b0, tag);
    sendChar(d, n, cfgParEn, parBit, stopBit);
  endtask

  // Monitor: pop and compare each delivered character, then acknowledge it
  initial begin
    rdAck = 1'b0;
    forever begin
      @(negedge clk);
      if (rdAck) begin
        rdAck = 1'b0;
      end else if (rstN && rdValid && !holdReads) begin
        checks++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R9 unexpected character actual=%0h expected=none", rxData);
        end else begin
          eCur = expQ.pop_front();
          tCur = tagQ.pop_front();
          if ({rxData, statParity, statFraming, statBreak, statOverrun} !== eCur) begin
            bad++;
            $display("FAIL %s actual=%0h p%b f%b b%b o%b expected=%0h p%b f%b b%b o%b",
                     tCur, rxData, statParity, statFraming, statBreak, statOverrun,
                     eCur.d, eCur.p, eCur.f, eCur.b, eCur.o);
          end
        end
        rxCount++;
        rdAck = 1'b1;
      end
    end
  end

  initial begin
    brkStartCnt = 0;
    brkEndCnt   = 0;
    forever begin
      @(negedge clk);
      if (breakStart) brkStartCnt++;
      if (breakEnd)   brkEndCnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    checks     = 0;
    bad        = 0;
    rxCount    = 0;
    holdReads  = 1'b0;
    rstN       = 1'b0;
    serialIn   = 1'b1;
    cfgLen     = 2'd3;
    cfgParEn   = 1'b0;
    cfgParMode = 2'd0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 rdValid in reset", rdValid, 0);
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    chk("R1 rdValid after reset", rdValid, 0);
    chk("R1 breakStart after reset", breakStart, 0);
    chk("R1 breakEnd after reset", breakEnd, 0);

    // R3: eight bits, then five bits
    xmit(8'hA5, 8, 1'b0, 1'b1, "R3 len8 A5");
    xmit(8'h3C, 8, 1'b0, 1'b1, "R3 len8 3C");
    cfgLen = 2'd0;
    xmit(8'hF5, 5, 1'b0, 1'b1, "R3 len5 upper zero");
    cfgLen = 2'd1;
    xmit(8'h2E, 6, 1'b0, 1'b1, "R3 len6");

    // R4: parity modes
    cfgParEn = 1'b1;
    cfgLen = 2'd2; cfgParMode = 2'd0;
    xmit(8'h5A, 7, calcPar(8'h5A, 7, 2'd0), 1'b1, "R4 even good");
    xmit(8'h5B, 7, calcPar(8'h5B, 7, 2'd1), 1'b1, "R4 even bad");
    cfgLen = 2'd0; cfgParMode = 2'd1;
    xmit(8'h13, 5, 1'b1, 1'b1, "R4 odd bad");
    xmit(8'h13, 5, 1'b0, 1'b1, "R4 odd good");
    cfgLen = 2'd3; cfgParMode = 2'd3;
    xmit(8'hF0, 8, 1'b1, 1'b1, "R4 force1 good");
    cfgParMode = 2'd2;
    xmit(8'hF0, 8, 1'b1, 1'b1, "R4 force0 bad");
    cfgParEn = 1'b0;

    // R5: stop bit low
    xmit(8'h81, 8, 1'b0, 1'b0, "R5 framing");
    setLine(1'b1, 3 * BIT_TICKS);
    @(negedge clk);
    chk("R5 queue drained", expQ.size(), 0);

    // R2: glitch shorter than half a bit
    snapCount = rxCount;
    setLine(1'b0, 4);
    setLine(1'b1, 3 * BIT_TICKS);
    @(negedge clk);
    chk("R2 false start no char", rxCount, snapCount);
    chk("R2 false start rdValid", rdValid, 0);
    xmit(8'h69, 8, 1'b0, 1'b1, "R2 hunting resumed");

    // R6 R7: full-frame break
    snapCount = rxCount;
    snapStart = brkStartCnt;
    pushExp(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R6 break char");
    setLine(1'b0, 14 * BIT_TICKS);
    @(negedge clk);
    chk("R6 breakStart pulse", brkStartCnt, snapStart + 1);
    chk("R7 no breakEnd while low", brkEndCnt, 0);
    chk("R7 one char during break", rxCount, snapCount + 1);
    setLine(1'b1, 3 * BIT_TICKS);
    @(negedge clk);
    chk("R7 breakEnd pulse", brkEndCnt, 1);

    // R8: break beginning after two data bits
    snapStart = brkStartCnt;
    pushExp(8'h03, 1'b0, 1'b1, 1'b0, 1'b0, "R8 cut char framing");
    pushExp(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R8 break char");
    setLine(1'b0, BIT_TICKS);
    setLine(1'b1, 2 * BIT_TICKS);
    setLine(1'b0, 30 * BIT_TICKS);
    @(negedge clk);
    chk("R8 breakStart pulse", brkStartCnt, snapStart + 1);
    chk("R8 no breakEnd yet", brkEndCnt, 1);
    setLine(1'b1, 3 * BIT_TICKS);
    @(negedge clk);
    chk("R8 breakEnd pulse", brkEndCnt, 2);

    // R9 R10: host stalls, second character overruns
    holdReads = 1'b1;
    pushExp(8'h47, 1'b0, 1'b0, 1'b0, 1'b1, "R10 held char with overrun");
    sendChar(8'h47, 8, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 held valid", rdValid, 1);
    chk("R9 held data", rxData, 8'h47);
    chk("R10 no overrun yet", statOverrun, 0);
    sendChar(8'hB8, 8, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 data kept", rxData, 8'h47);
    chk("R10 overrun set", statOverrun, 1);
    holdReads = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 cleared by read", rdValid, 0);
    chk("R10 overrun cleared", statOverrun, 0);
    xmit(8'h5E, 8, 1'b0, 1'b1, "R10 next char stored");

    repeat (20) @(negedge clk);
    chk("R9 all expected chars seen", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule